// File: doc/BRIEF.md
# Transmit buffer state machine

This block follows one transmit frame buffer of a CAN-style controller through its life: idle, queued for sending, owned by the protocol engine, and finished in one of several end states. Host software drives it with three commands (mark ready, mark empty, request abort). Each command is honoured only when this buffer's bit in a buffer-select vector is set. The protocol engine drives it with five commands (lock, success, bus error, arbitration lost, failure), and these are honoured only while the engine's command select is high. A parity-error flag from the storage side and a clock enable complete the inputs.

A host command and an engine command can arrive in the same cycle, and the block resolves that case deterministically. An abort that coincides with a lock is not lost: the buffer becomes owned and the abort stays pending. An abort that coincides with an unsuccessful end of transmission retires the buffer as aborted and does not requeue it. A parity error in any active state overrides every other command. The current state code and two registered flags (ready and locked) are presented to the buffer-selection logic and to host-visible status.

Top module: `txb_state_machine`

## Requirements
- R1: After a synchronous reset the state code is EMPTY, and `ready_o` and `locked_o` are 0. The state codes are EMPTY=0, READY=1, TX_BUSY=2, ABORT_BUSY=3, DONE=4, FAILED=5, ABORTED=6, PARITY_FAULT=7.
- R2: A host command counts only when `sw_buf_sel[BUF_IDX]` is 1. An engine command counts only when `hw_cs` is 1. When the relevant select is low, the command has no effect.
- R3: The state changes only on an edge where `fsm_ce` is 1. Otherwise the state and both flags hold.
- R4: Mark-ready moves EMPTY, DONE, FAILED, ABORTED or PARITY_FAULT to READY. In those terminal states it takes priority over mark-empty.
- R5: Mark-empty moves DONE, FAILED, ABORTED or PARITY_FAULT to EMPTY. It is ignored in EMPTY, READY, TX_BUSY and ABORT_BUSY.
- R6: In READY, lock goes to TX_BUSY. Abort alone goes to ABORTED. Lock together with abort goes to ABORT_BUSY.
- R7: In TX_BUSY with no abort, success goes to DONE, failure goes to FAILED, and bus error or arbitration lost goes back to READY. Abort with no engine command goes to ABORT_BUSY. Success has priority over failure, and failure has priority over error or arbitration lost.
- R8: In TX_BUSY, an abort together with bus error, arbitration lost or failure, and without success, goes to ABORTED.
- R9: In ABORT_BUSY, success goes to DONE, failure goes to FAILED, and bus error or arbitration lost goes to ABORTED.
- R10: A parity error in READY, TX_BUSY or ABORT_BUSY goes to PARITY_FAULT, overriding all other commands. In the other states the parity error has no effect.
- R11: `ready_o` is 1 exactly in READY. `locked_o` is 1 exactly in TX_BUSY and ABORT_BUSY. Both flags are registered and change on the same edge as `state_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fsm_ce | input | 1 | State-machine clock enable |
| sw_set_ready | input | 1 | Host command: mark ready |
| sw_set_empty | input | 1 | Host command: mark empty |
| sw_set_abort | input | 1 | Host command: request abort |
| sw_buf_sel | input | NUM_BUFS | Buffer-select vector for host commands |
| hw_cs | input | 1 | Engine command select for this buffer |
| hw_lock | input | 1 | Engine takes the buffer for transmission |
| hw_valid | input | 1 | Transmission succeeded |
| hw_err | input | 1 | Bus error during transmission |
| hw_arbl | input | 1 | Arbitration lost |
| hw_failed | input | 1 | Transmission failed for good |
| parity_err | input | 1 | Parity error in buffer storage |
| state_o | output | 3 | Current state code |
| ready_o | output | 1 | Buffer is ready to be picked |
| locked_o | output | 1 | Buffer is owned by the engine |

## Verification
The bench builds the block with NUM_BUFS=2 and BUF_IDX=1. Bit 0 of the select vector therefore belongs to a neighbouring buffer, so a command aimed only at that neighbour can be shown to leave this buffer untouched. With this small configuration, every start state can be swept against all 2048 combinations of host commands, select match, engine select, the five engine commands and parity error. That sweep covers every same-cycle hazard and every priority order. A thinner sweep with the enable low covers the hold behaviour.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int TXB_STATE_W = 3;

  typedef enum logic [TXB_STATE_W-1:0] {
    TXB_EMPTY        = 3'd0,
    TXB_READY        = 3'd1,
    TXB_TX_BUSY      = 3'd2,
    TXB_ABORT_BUSY   = 3'd3,
    TXB_DONE         = 3'd4,
    TXB_FAILED       = 3'd5,
    TXB_ABORTED      = 3'd6,
    TXB_PARITY_FAULT = 3'd7
  } txb_state_e;

  typedef struct packed {
    logic ready;
    logic empty;
    logic abort;
  } txb_sw_cmd_t;

  typedef struct packed {
    logic lock;
    logic valid;
    logic err;
    logic arbl;
    logic failed;
  } txb_hw_cmd_t;
endpackage

// File: rtl/txb_cmd_gate.sv
module txb_cmd_gate
  import txb_pkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int BUF_IDX  = 0
) (
  input  logic                sw_set_ready,
  input  logic                sw_set_empty,
  input  logic                sw_set_abort,
  input  logic [NUM_BUFS-1:0] sw_buf_sel,
  input  logic                hw_cs,
  input  logic                hw_lock,
  input  logic                hw_valid,
  input  logic                hw_err,
  input  logic                hw_arbl,
  input  logic                hw_failed,
  output txb_sw_cmd_t         sw_cmd,
  output txb_hw_cmd_t         hw_cmd
);
  logic sel_hit;

  // An index outside the vector means no host command can ever reach this buffer.
  generate
    if (BUF_IDX < NUM_BUFS) begin : g_sel_in_range
      assign sel_hit = sw_buf_sel[BUF_IDX];
    end else begin : g_sel_out_of_range
      assign sel_hit = 1'b0;
    end
  endgenerate

  assign sw_cmd.ready  = sw_set_ready & sel_hit;
  assign sw_cmd.empty  = sw_set_empty & sel_hit;
  assign sw_cmd.abort  = sw_set_abort & sel_hit;

  assign hw_cmd.lock   = hw_lock   & hw_cs;
  assign hw_cmd.valid  = hw_valid  & hw_cs;
  assign hw_cmd.err    = hw_err    & hw_cs;
  assign hw_cmd.arbl   = hw_arbl   & hw_cs;
  assign hw_cmd.failed = hw_failed & hw_cs;
endmodule

// File: rtl/txb_next_state.sv
module txb_next_state
  import txb_pkg::*;
(
  input  txb_state_e  cur,
  input  txb_sw_cmd_t sw_cmd,
  input  txb_hw_cmd_t hw_cmd,
  input  logic        parity_err,
  output txb_state_e  nxt
);
  logic retry_cause;
  logic stop_cause;

  assign retry_cause = hw_cmd.err | hw_cmd.arbl;
  assign stop_cause  = retry_cause | hw_cmd.failed;

  always_comb begin
    nxt = cur;
    unique case (cur)
      TXB_EMPTY: begin
        if (sw_cmd.ready) nxt = TXB_READY;
      end
      TXB_READY: begin
        if (parity_err)                       nxt = TXB_PARITY_FAULT;
        else if (hw_cmd.lock && sw_cmd.abort) nxt = TXB_ABORT_BUSY;
        else if (hw_cmd.lock)                 nxt = TXB_TX_BUSY;
        else if (sw_cmd.abort)                nxt = TXB_ABORTED;
      end
      TXB_TX_BUSY: begin
        if (parity_err)                       nxt = TXB_PARITY_FAULT;
        else if (hw_cmd.valid)                nxt = TXB_DONE;
        else if (sw_cmd.abort && stop_cause)  nxt = TXB_ABORTED;
        else if (hw_cmd.failed)               nxt = TXB_FAILED;
        else if (retry_cause)                 nxt = TXB_READY;
        else if (sw_cmd.abort)                nxt = TXB_ABORT_BUSY;
      end
      TXB_ABORT_BUSY: begin
        if (parity_err)                       nxt = TXB_PARITY_FAULT;
        else if (hw_cmd.valid)                nxt = TXB_DONE;
        else if (hw_cmd.failed)               nxt = TXB_FAILED;
        else if (retry_cause)                 nxt = TXB_ABORTED;
      end
      TXB_DONE, TXB_FAILED, TXB_ABORTED, TXB_PARITY_FAULT: begin
        if (sw_cmd.ready)      nxt = TXB_READY;
        else if (sw_cmd.empty) nxt = TXB_EMPTY;
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/txb_flag_decode.sv
module txb_flag_decode
  import txb_pkg::*;
(
  input  txb_state_e st,
  output logic       ready_flag,
  output logic       locked_flag
);
  assign ready_flag  = (st == TXB_READY);
  assign locked_flag = (st == TXB_TX_BUSY) || (st == TXB_ABORT_BUSY);
endmodule

// File: rtl/txb_state_machine.sv
module txb_state_machine
  import txb_pkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int BUF_IDX  = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fsm_ce,
  input  logic                   sw_set_ready,
  input  logic                   sw_set_empty,
  input  logic                   sw_set_abort,
  input  logic [NUM_BUFS-1:0]    sw_buf_sel,
  input  logic                   hw_cs,
  input  logic                   hw_lock,
  input  logic                   hw_valid,
  input  logic                   hw_err,
  input  logic                   hw_arbl,
  input  logic                   hw_failed,
  input  logic                   parity_err,
  output logic [TXB_STATE_W-1:0] state_o,
  output logic                   ready_o,
  output logic                   locked_o
);
  txb_sw_cmd_t sw_cmd;
  txb_hw_cmd_t hw_cmd;
  txb_state_e  state_q;
  txb_state_e  state_nxt;
  txb_state_e  state_d;
  logic        ready_d;
  logic        locked_d;

  txb_cmd_gate #(.NUM_BUFS(NUM_BUFS), .BUF_IDX(BUF_IDX)) gate_i (
    .sw_set_ready (sw_set_ready),
    .sw_set_empty (sw_set_empty),
    .sw_set_abort (sw_set_abort),
    .sw_buf_sel   (sw_buf_sel),
    .hw_cs        (hw_cs),
    .hw_lock      (hw_lock),
    .hw_valid     (hw_valid),
    .hw_err       (hw_err),
    .hw_arbl      (hw_arbl),
    .hw_failed    (hw_failed),
    .sw_cmd       (sw_cmd),
    .hw_cmd       (hw_cmd)
  );

  txb_next_state nxt_i (
    .cur        (state_q),
    .sw_cmd     (sw_cmd),
    .hw_cmd     (hw_cmd),
    .parity_err (parity_err),
    .nxt        (state_nxt)
  );

  assign state_d = fsm_ce ? state_nxt : state_q;

  txb_flag_decode flags_i (
    .st          (state_d),
    .ready_flag  (ready_d),
    .locked_flag (locked_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= TXB_EMPTY;
      ready_o  <= 1'b0;
      locked_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      ready_o  <= ready_d;
      locked_o <= locked_d;
    end
  end

  assign state_o = state_q;

  // R3
  hold_without_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !fsm_ce |=> $stable(state_o) && $stable(ready_o) && $stable(locked_o));

  // R10
  parity_fault_entry_chk: assert property (@(posedge clk) disable iff (rst)
    fsm_ce && parity_err &&
    (state_o == TXB_READY || state_o == TXB_TX_BUSY || state_o == TXB_ABORT_BUSY)
    |=> state_o == TXB_PARITY_FAULT);

  // R6
  lock_abort_hazard_chk: assert property (@(posedge clk) disable iff (rst)
    fsm_ce && !parity_err && state_o == TXB_READY && hw_cs && hw_lock &&
    sw_set_abort && sw_buf_sel[BUF_IDX]
    |=> state_o == TXB_ABORT_BUSY);

  // R5
  no_empty_from_active_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == TXB_READY || state_o == TXB_TX_BUSY || state_o == TXB_ABORT_BUSY)
    |=> state_o != TXB_EMPTY);

  // R2
  hw_select_gate_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == TXB_READY && !hw_cs && !parity_err &&
    !(sw_set_abort && sw_buf_sel[BUF_IDX])
    |=> state_o == TXB_READY);

  // R11
  flags_follow_state_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_o == (state_o == TXB_READY)) &&
    (locked_o == (state_o == TXB_TX_BUSY || state_o == TXB_ABORT_BUSY)));
endmodule

// File: tb/txb_state_machine_tb_top.sv
module txb_state_machine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 2;
  localparam int IDX = 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          fsm_ce, sw_set_ready, sw_set_empty, sw_set_abort;
  logic [NB-1:0] sw_buf_sel;
  logic          hw_cs, hw_lock, hw_valid, hw_err, hw_arbl, hw_failed, parity_err;
  logic [2:0]    state_o;
  logic          ready_o, locked_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txb_state_machine #(.NUM_BUFS(NB), .BUF_IDX(IDX)) dut_i (
    .clk, .rst, .fsm_ce, .sw_set_ready, .sw_set_empty, .sw_set_abort,
    .sw_buf_sel, .hw_cs, .hw_lock, .hw_valid, .hw_err, .hw_arbl,
    .hw_failed, .parity_err, .state_o, .ready_o, .locked_o
  );

  // Expected next state from the requirements (codes per R1).
  function automatic int model(int st, bit ce, bit sr, bit se, bit sa, bit hit,
                               bit cs, bit lk, bit vd, bit er, bit al, bit fl, bit pe);
    bit r = sr & hit, e = se & hit, a = sa & hit;
    bit l = lk & cs, v = vd & cs, x = (er | al) & cs, f = fl & cs;
    if (!ce) return st;                                   // R3
    case (st)
      0: return r ? 1 : 0;                                // R4, R5
      1: begin                                            // R6, R10
        if (pe) return 7;
        if (l && a) return 3;
        if (l) return 2;
        if (a) return 6;
        return 1;
      end
      2: begin                                            // R7, R8, R10
        if (pe) return 7;
        if (v) return 4;
        if (a && (x || f)) return 6;
        if (f) return 5;
        if (x) return 1;
        if (a) return 3;
        return 2;
      end
      3: begin                                            // R9, R10
        if (pe) return 7;
        if (v) return 4;
        if (f) return 5;
        if (x) return 6;
        return 3;
      end
      default: begin                                      // R4, R5
        if (r) return 1;
        if (e) return 0;
        return st;
      end
    endcase
  endfunction

  function automatic string tag_of(int st, bit ce, bit sr, bit se, bit sa, bit hit,
                                   bit cs, bit fl, bit er, bit al, bit vd, bit pe);
    if (!ce) return "R3";
    if (pe && st >= 1 && st <= 3) return "R10";
    if (st == 0 || st >= 4) begin
      if (!hit && (sr || se)) return "R2";
      if (sr) return "R4";
      return "R5";
    end
    if (st == 1) return "R6";
    if (st == 3) return "R9";
    if (sa && hit && cs && (fl || er || al) && !vd) return "R8";
    return "R7";
  endfunction

  task automatic drive(bit ce, bit sr, bit se, bit sa, bit hit, bit cs,
                       bit lk, bit vd, bit er, bit al, bit fl, bit pe);
    fsm_ce = ce; sw_set_ready = sr; sw_set_empty = se; sw_set_abort = sa;
    sw_buf_sel = hit ? 2'b10 : 2'b01;
    hw_cs = cs; hw_lock = lk; hw_valid = vd; hw_err = er; hw_arbl = al;
    hw_failed = fl; parity_err = pe;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle();
    rst = 1'b0;
  endtask

  task automatic check(string tag, int exp_st);
    bit exp_r = (exp_st == 1);
    bit exp_l = (exp_st == 2 || exp_st == 3);
    n_checks++;
    if (state_o !== exp_st[2:0] || ready_o !== exp_r || locked_o !== exp_l) begin
      n_fails++;
      $display("FAIL %s/R11: state=%0d ready=%0b locked=%0b expected state=%0d ready=%0b locked=%0b",
               tag, state_o, ready_o, locked_o, exp_st, exp_r, exp_l);
    end
  endtask

  task automatic goto_state(int s);
    do_reset();
    if (s != 0) drive(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    case (s)
      2: drive(1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0);
      3: drive(1, 0, 0, 1, 1, 1, 1, 0, 0, 0, 0, 0);
      4: begin drive(1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0); drive(1, 0, 0, 0, 1, 1, 0, 1, 0, 0, 0, 0); end
      5: begin drive(1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0); drive(1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 1, 0); end
      6: drive(1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
      7: drive(1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1);
      default: ;
    endcase
  endtask

  task automatic trial(int s, bit ce, int v);
    bit sr = v[0], se = v[1], sa = v[2], hit = v[3], cs = v[4];
    bit lk = v[5], vd = v[6], er = v[7], al = v[8], fl = v[9], pe = v[10];
    goto_state(s);
    drive(ce, sr, se, sa, hit, cs, lk, vd, er, al, fl, pe);
    check(tag_of(s, ce, sr, se, sa, hit, cs, fl, er, al, vd, pe),
          model(s, ce, sr, se, sa, hit, cs, lk, vd, er, al, fl, pe));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    fsm_ce = 0; sw_set_ready = 0; sw_set_empty = 0; sw_set_abort = 0;
    sw_buf_sel = '0; hw_cs = 0; hw_lock = 0; hw_valid = 0; hw_err = 0;
    hw_arbl = 0; hw_failed = 0; parity_err = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1", 0);

    // R2: a command aimed only at the neighbour (bit 0) must not move this buffer.
    goto_state(0);
    drive(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R2", 0);
    // R2: a lock with the engine select low is ignored in READY.
    goto_state(1);
    drive(1, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
    check("R2", 1);

    // Full sweep with the enable high: every state against every input combination.
    for (int s = 0; s < 8; s++)
      for (int v = 0; v < 2048; v++)
        trial(s, 1'b1, v);

    // Enable low: nothing may move (R3).
    for (int s = 0; s < 8; s++)
      for (int v = 0; v < 2048; v += 37)
        trial(s, 1'b0, v);

    // R1: reset from a busy state returns to EMPTY.
    goto_state(3);
    do_reset();
    check("R1", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule